// File: doc/BRIEF.md
# Accumulator Processor with Post-Instruction Interrupt Check

This block is a small one-address processor built around a single accumulator. It steps through a fetch sequence, an execute sequence chosen by the fetched opcode, and then a separate check cycle. In that check cycle it either stops the machine on a fault, jumps to a vector supplied from outside, or returns to fetch. It reaches a synchronous word-addressed memory through one port that can read or write. That port shares the memory address and memory data registers of the datapath.

Each instruction word holds an opcode in the upper bits and a memory address in the lower bits. The decoder register is the micro-sequencer: it holds the fetch code, the code of the instruction being executed, or the check code, and a small step counter walks the register transfers of that code. Memory-protection and privilege checks are made elsewhere and arrive as fault inputs. An external interrupt unit watches the system-call flag and the check-cycle strobe, and decides whether control moves to a new address.

Top module: `acc_cpu`

## Requirements
- R1: On reset, IP takes `reset_vec` and the accumulator, the overflow flag, the system-call flag and the system-call index are zero. `halted` and `abend` are low, and the decoder holds the fetch code 0x00.
- R2: An instruction word is 16 bits: opcode in bits 15:8 and address in bits 7:0. Fetch takes five cycles: MAR<-IP, memory read wait, MDR<-memory, IR<-MDR with IP<-IP+1 (wrapping at 8 bits), then decoder<-opcode.
- R3: Opcode 0x01 (load) takes four cycles and sets the accumulator to the memory word at the address field.
- R4: Opcode 0x02 (add) takes four cycles and adds the memory word at the address field to the accumulator, wrapping at 16 bits. A two's-complement overflow sets the overflow flag, which then stays set until reset. An unsigned carry without signed overflow leaves the flag clear.
- R5: Opcode 0x03 (store) takes three cycles: MAR<-address, MDR<-accumulator, then the memory write. It writes the accumulator to the memory word at the address field.
- R6: Opcode 0x04 (end) asserts `halted` one cycle after decode, with `abend` low. From then on no output changes until reset.
- R7: Load, add, store, system call and opcodes 0x07-0xFF are followed by exactly one check cycle, with `in_check` high for that one cycle, before the next fetch.
- R8: Opcode 0x06 (system call) takes one cycle. It copies the address field into `svc_index` and sets `svc_flag`.
- R9: In the check cycle, a set overflow flag, `fault_mem` or `fault_priv` stops the machine with both `halted` and `abend` high, and IP is left unchanged. A fault takes priority over `irq_go`.
- R10: In a check cycle with no fault and `irq_go` high, IP takes `irq_vec` and `svc_flag` clears. With `irq_go` low, IP and `svc_flag` are kept.
- R11: Opcode 0x00 returns straight to fetch. Opcode 0x05 goes straight to the check cycle. Opcodes 0x07-0xFF spend one cycle and then go to check. None of these changes the accumulator or memory.
- R12: The memory port is synchronous. Read data appears one clock after the address. `mem_we` is raised for one cycle, during which `mem_wdata` equals the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reset_vec | input | 8 | Start address loaded into IP at reset |
| mem_addr | output | 8 | Memory word address (MAR) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (MDR) |
| mem_rdata | input | 16 | Registered memory read data |
| fault_mem | input | 1 | Memory-protection fault from outside checker |
| fault_priv | input | 1 | Privilege fault from outside checker |
| irq_go | input | 1 | Interrupt unit requests a jump in the check cycle |
| irq_vec | input | 8 | Jump target used when `irq_go` is honoured |
| ip | output | 8 | Instruction pointer |
| acc | output | 16 | Accumulator |
| ov_flag | output | 1 | Sticky signed-overflow flag |
| svc_flag | output | 1 | System-call pending flag |
| svc_index | output | 8 | Index latched by the last system call |
| in_check | output | 1 | High during the check cycle |
| halted | output | 1 | Machine stopped |
| abend | output | 1 | Stop was abnormal |

## Verification
Short programs are run against a reference model that updates on every clock. A plain load-add-store-end sequence confirms the transfer timing and the sum. Two add cases overflow, one positive and one negative, and they confirm that the check cycle stops the machine before the following store. A case that carries out of 16 bits without signed overflow tells the signed overflow test apart from an unsigned carry. System calls run once with the interrupt unit following `svc_flag` and once with it idle, which separates the redirect from the plain return to fetch. A held privilege fault, and a run of opcodes 0x00, 0x05 and unassigned values, show the fault stop and the no-operation paths.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // Decoder codes: fetch, instruction opcodes, and the post-instruction check.
  localparam int CODE_FETCH = 8'h00;
  localparam int CODE_LOAD  = 8'h01;
  localparam int CODE_ADD   = 8'h02;
  localparam int CODE_STORE = 8'h03;
  localparam int CODE_END   = 8'h04;
  localparam int CODE_CHECK = 8'h05;
  localparam int CODE_SVC   = 8'h06;

  // Register-transfer strobes from the sequencer to the datapath.
  typedef struct packed {
    logic mar_from_ip;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic ir_load;
    logic ip_inc;
    logic acc_from_mdr;
    logic acc_from_sum;
    logic mem_write;
    logic svc_latch;
    logic vec_take;
  } ctl_t;

  // Two's-complement overflow from the sign bits of operands and sum.
  function automatic logic signed_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf
);
  import acc_cpu_pkg::*;

  always_comb begin
    sum = a + b;
    ovf = signed_ovf(a[W-1], b[W-1], sum[W-1]);
  end

endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer #(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   ir_op,
  input  logic              ov_q,
  input  logic              fault_mem,
  input  logic              fault_priv,
  input  logic              irq_go,
  output acc_cpu_pkg::ctl_t ctl,
  output logic              in_check,
  output logic              halted,
  output logic              abend
);
  import acc_cpu_pkg::*;

  localparam int STEP_W = 3;
  localparam logic [OP_W-1:0] C_FETCH = OP_W'(CODE_FETCH);
  localparam logic [OP_W-1:0] C_LOAD  = OP_W'(CODE_LOAD);
  localparam logic [OP_W-1:0] C_ADD   = OP_W'(CODE_ADD);
  localparam logic [OP_W-1:0] C_STORE = OP_W'(CODE_STORE);
  localparam logic [OP_W-1:0] C_END   = OP_W'(CODE_END);
  localparam logic [OP_W-1:0] C_CHECK = OP_W'(CODE_CHECK);
  localparam logic [OP_W-1:0] C_SVC   = OP_W'(CODE_SVC);

  logic [OP_W-1:0]   dec_q, dec_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              halted_q, abend_q, halt_set, abend_set;
  logic              fault_any;

  assign fault_any = ov_q | fault_mem | fault_priv;

  always_comb begin
    ctl       = '0;
    dec_d     = dec_q;
    step_d    = step_q + 1'b1;
    halt_set  = 1'b0;
    abend_set = 1'b0;
    if (halted_q) begin
      step_d = step_q;
    end else if (dec_q == C_FETCH) begin
      case (step_q)
        STEP_W'(0): ctl.mar_from_ip  = 1'b1;
        STEP_W'(2): ctl.mdr_from_mem = 1'b1;
        STEP_W'(3): begin ctl.ir_load = 1'b1; ctl.ip_inc = 1'b1; end
        STEP_W'(4): begin dec_d = ir_op; step_d = '0; end
        default: ;
      endcase
    end else if (dec_q == C_LOAD || dec_q == C_ADD) begin
      case (step_q)
        STEP_W'(0): ctl.mar_from_ir  = 1'b1;
        STEP_W'(2): ctl.mdr_from_mem = 1'b1;
        STEP_W'(3): begin
          ctl.acc_from_mdr = (dec_q == C_LOAD);
          ctl.acc_from_sum = (dec_q == C_ADD);
          dec_d = C_CHECK; step_d = '0;
        end
        default: ;
      endcase
    end else if (dec_q == C_STORE) begin
      case (step_q)
        STEP_W'(0): ctl.mar_from_ir  = 1'b1;
        STEP_W'(1): ctl.mdr_from_acc = 1'b1;
        STEP_W'(2): begin ctl.mem_write = 1'b1; dec_d = C_CHECK; step_d = '0; end
        default: ;
      endcase
    end else if (dec_q == C_END) begin
      halt_set = 1'b1;
      step_d   = step_q;
    end else if (dec_q == C_SVC) begin
      ctl.svc_latch = 1'b1;
      dec_d = C_CHECK; step_d = '0;
    end else if (dec_q == C_CHECK) begin
      if (fault_any) begin
        halt_set  = 1'b1;
        abend_set = 1'b1;
        step_d    = step_q;
      end else begin
        ctl.vec_take = irq_go;
        dec_d = C_FETCH; step_d = '0;
      end
    end else begin
      dec_d = C_CHECK; step_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q    <= C_FETCH;
      step_q   <= '0;
      halted_q <= 1'b0;
      abend_q  <= 1'b0;
    end else if (!halted_q) begin
      dec_q    <= dec_d;
      step_q   <= step_d;
      halted_q <= halt_set;
      abend_q  <= abend_set;
    end
  end

  assign in_check = (dec_q == C_CHECK) && !halted_q;
  assign halted   = halted_q;
  assign abend    = abend_q;

  // Event wires for the checks below.
  logic ev_fault_stop;
  assign ev_fault_stop = in_check && fault_any;

  assert_check_single_R7: assert property (@(posedge clk) disable iff (rst)
    in_check |=> !in_check);
  assert_halt_holds_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(abend));
  assert_abend_is_halt_R9: assert property (@(posedge clk) disable iff (rst)
    abend |-> halted);
  assert_fault_stops_R9: assert property (@(posedge clk) disable iff (rst)
    ev_fault_stop |=> halted && abend);

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  acc_cpu_pkg::ctl_t      ctl,
  input  logic [ADDR_W-1:0]      reset_vec,
  input  logic [ADDR_W-1:0]      irq_vec,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic [DATA_W-ADDR_W-1:0] ir_op,
  output logic [ADDR_W-1:0]      ip,
  output logic [DATA_W-1:0]      acc,
  output logic                   ov_flag,
  output logic                   svc_flag,
  output logic [ADDR_W-1:0]      svc_index,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata
);
  localparam int OP_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] ip_q, mar_q, b_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q, sum_w;
  logic              ov_q, svc_q, ovf_w;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_addr = ir_q[ADDR_W-1:0];
  assign ir_op   = ir_q[DATA_W-1:ADDR_W];

  acc_alu #(.W(DATA_W)) u_alu (
    .a  (acc_q),
    .b  (mdr_q),
    .sum(sum_w),
    .ovf(ovf_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q  <= reset_vec;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      b_q   <= '0;
      ov_q  <= 1'b0;
      svc_q <= 1'b0;
    end else begin
      if (ctl.mar_from_ip)  mar_q <= ip_q;
      if (ctl.mar_from_ir)  mar_q <= ir_addr;
      if (ctl.mdr_from_mem) mdr_q <= mem_rdata;
      if (ctl.mdr_from_acc) mdr_q <= acc_q;
      if (ctl.ir_load)      ir_q  <= mdr_q;
      if (ctl.ip_inc)       ip_q  <= ip_q + 1'b1;
      if (ctl.acc_from_mdr) acc_q <= mdr_q;
      if (ctl.acc_from_sum) begin
        acc_q <= sum_w;
        if (ovf_w) ov_q <= 1'b1;
      end
      if (ctl.svc_latch) begin
        svc_q <= 1'b1;
        b_q   <= ir_addr;
      end
      if (ctl.vec_take) begin
        ip_q  <= irq_vec;
        svc_q <= 1'b0;
      end
    end
  end

  assign ip        = ip_q;
  assign acc       = acc_q;
  assign ov_flag   = ov_q;
  assign svc_flag  = svc_q;
  assign svc_index = b_q;
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;

  logic unused_op;
  assign unused_op = ^ir_op[OP_W-1:0] & 1'b0;

  assert_ov_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ov_q |=> ov_q);
  assert_ip_step_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.ip_inc |=> ip_q == $past(ip_q) + 1'b1);
  assert_vector_taken_R10: assert property (@(posedge clk) disable iff (rst)
    ctl.vec_take |=> (ip_q == $past(irq_vec)) && !svc_q);
  assert_write_data_R12: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_write |-> mem_wdata == acc_q);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reset_vec,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              fault_mem,
  input  logic              fault_priv,
  input  logic              irq_go,
  input  logic [ADDR_W-1:0] irq_vec,
  output logic [ADDR_W-1:0] ip,
  output logic [DATA_W-1:0] acc,
  output logic              ov_flag,
  output logic              svc_flag,
  output logic [ADDR_W-1:0] svc_index,
  output logic              in_check,
  output logic              halted,
  output logic              abend
);
  import acc_cpu_pkg::*;

  localparam int OP_W = DATA_W - ADDR_W;

  ctl_t            ctl;
  logic [OP_W-1:0] ir_op;

  acc_sequencer #(.OP_W(OP_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ir_op     (ir_op),
    .ov_q      (ov_flag),
    .fault_mem (fault_mem),
    .fault_priv(fault_priv),
    .irq_go    (irq_go),
    .ctl       (ctl),
    .in_check  (in_check),
    .halted    (halted),
    .abend     (abend)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .reset_vec(reset_vec),
    .irq_vec  (irq_vec),
    .mem_rdata(mem_rdata),
    .ir_op    (ir_op),
    .ip       (ip),
    .acc      (acc),
    .ov_flag  (ov_flag),
    .svc_flag (svc_flag),
    .svc_index(svc_index),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  assign mem_we = ctl.mem_write;

  assert_write_ends_in_check_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> in_check);
  assert_halt_freezes_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(ip) && $stable(acc) && !mem_we);

endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reset_vec = 8'h10;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        fault_mem = 1'b0;
  logic        fault_priv = 1'b0;
  logic        irq_go;
  logic [7:0]  irq_vec = 8'h40;
  logic [7:0]  ip;
  logic [15:0] acc;
  logic        ov_flag, svc_flag, in_check, halted, abend;
  logic [7:0]  svc_index;

  logic        follow_svc = 1'b0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;
  logic [15:0] bmem [256];

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  assign irq_go = follow_svc & svc_flag;

  // Bench-side memory: registered read, write on strobe, loader port.
  always @(posedge clk) begin
    if (ld_en) bmem[ld_a] <= ld_d;
    else if (mem_we) bmem[mem_addr] <= mem_wdata;
    mem_rdata <= bmem[mem_addr];
  end

  acc_cpu i_acc_cpu (
    .clk(clk), .rst(rst), .reset_vec(reset_vec),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fault_mem(fault_mem), .fault_priv(fault_priv), .irq_go(irq_go), .irq_vec(irq_vec),
    .ip(ip), .acc(acc), .ov_flag(ov_flag), .svc_flag(svc_flag), .svc_index(svc_index),
    .in_check(in_check), .halted(halted), .abend(abend)
  );

  // Reference model state (value after the coming clock edge once stepped).
  int          m_ph;   // 0 fetch, 1 execute, 2 check, 3 stopped
  int          m_cnt;
  logic [7:0]  m_op, m_addr, m_ip, m_b;
  logic [15:0] m_a;
  logic        m_ov, m_svc, m_halt, m_abend;
  logic [15:0] m_mem [256];

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    ld_a = a; ld_d = d; ld_en = 1'b1;
    m_mem[a] = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
  endtask

  task automatic model_reset();
    m_ph = 0; m_cnt = 0; m_op = '0; m_addr = '0; m_ip = reset_vec; m_b = '0;
    m_a = '0; m_ov = 1'b0; m_svc = 1'b0; m_halt = 1'b0; m_abend = 1'b0;
  endtask

  task automatic model_step();
    int sa, sb, s;
    logic [15:0] w;
    if (m_halt) return;
    case (m_ph)
      0: begin
        if (m_cnt == 3) begin
          w = m_mem[m_ip]; m_op = w[15:8]; m_addr = w[7:0]; m_ip = m_ip + 8'd1;
        end
        if (m_cnt == 4) begin
          m_cnt = 0;
          m_ph = (m_op == 8'h00) ? 0 : (m_op == 8'h05) ? 2 : 1;
        end else m_cnt++;
      end
      1: begin
        case (m_op)
          8'h01: if (m_cnt == 3) begin m_a = m_mem[m_addr]; m_ph = 2; m_cnt = 0; end else m_cnt++;
          8'h02: if (m_cnt == 3) begin
                   sa = $signed(m_a); sb = $signed(m_mem[m_addr]); s = sa + sb;
                   if (s > 32767 || s < -32768) m_ov = 1'b1;
                   m_a = 16'(s); m_ph = 2; m_cnt = 0;
                 end else m_cnt++;
          8'h03: if (m_cnt == 2) begin m_mem[m_addr] = m_a; m_ph = 2; m_cnt = 0; end else m_cnt++;
          8'h04: begin m_halt = 1'b1; m_ph = 3; end
          8'h06: begin m_b = m_addr; m_svc = 1'b1; m_ph = 2; m_cnt = 0; end
          default: begin m_ph = 2; m_cnt = 0; end
        endcase
      end
      2: begin
        if (m_ov || fault_mem || fault_priv) begin
          m_halt = 1'b1; m_abend = 1'b1; m_ph = 3;
        end else begin
          if (follow_svc && m_svc) begin m_ip = irq_vec; m_svc = 1'b0; end
          m_ph = 0; m_cnt = 0;
        end
      end
      default: ;
    endcase
  endtask

  task automatic compare_all();
    chk("R2",  "ip",        {8'h00, ip},        {8'h00, m_ip});
    chk("R3",  "acc",       acc,                m_a);
    chk("R4",  "ov_flag",   {15'h0, ov_flag},   {15'h0, m_ov});
    chk("R8",  "svc_flag",  {15'h0, svc_flag},  {15'h0, m_svc});
    chk("R8",  "svc_index", {8'h00, svc_index}, {8'h00, m_b});
    chk("R7",  "in_check",  {15'h0, in_check},  {15'h0, (m_ph == 2)});
    chk("R6",  "halted",    {15'h0, halted},    {15'h0, m_halt});
    chk("R9",  "abend",     {15'h0, abend},     {15'h0, m_abend});
  endtask

  task automatic run_prog(input int ncyc);
    @(negedge clk);
    model_reset();
    rst = 1'b0;
    chk("R1", "reset ip",     {8'h00, ip}, {8'h00, reset_vec});
    chk("R1", "reset acc",    acc, 16'h0000);
    chk("R1", "reset status", {11'h0, ov_flag, svc_flag, in_check, halted, abend}, 16'h0000);
    for (int c = 0; c < ncyc; c++) begin
      compare_all();
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic fm, input logic fp, input logic fs);
    rst = 1'b1;
    fault_mem = fm; fault_priv = fp; follow_svc = fs;
    clear_mem();
  endtask

  task automatic mem_match(input string tag, input logic [7:0] a);
    chk(tag, "memory word", bmem[a], m_mem[a]);
  endtask

  initial begin
    // Basic load/add/store/end.
    setup(1'b0, 1'b0, 1'b0);
    poke(8'h20, 16'h01C2); poke(8'h21, 16'h012C);
    poke(8'h10, 16'h0120); poke(8'h11, 16'h0221); poke(8'h12, 16'h0322); poke(8'h13, 16'h0400);
    run_prog(70);
    chk("R5", "stored sum", bmem[8'h22], 16'h02EE);
    mem_match("R12", 8'h22);
    chk("R6", "normal end", {14'h0, halted, abend}, 16'h0002);

    // Positive overflow stops before the store.
    setup(1'b0, 1'b0, 1'b0);
    poke(8'h20, 16'h7FFF); poke(8'h21, 16'h0001);
    poke(8'h10, 16'h0120); poke(8'h11, 16'h0221); poke(8'h12, 16'h0322); poke(8'h13, 16'h0400);
    run_prog(70);
    chk("R9", "abend on overflow", {14'h0, halted, abend}, 16'h0003);
    chk("R9", "store skipped", bmem[8'h22], 16'h0000);
    chk("R4", "wrapped sum", acc, 16'h8000);

    // Negative overflow.
    setup(1'b0, 1'b0, 1'b0);
    poke(8'h20, 16'h8000); poke(8'h21, 16'hFFFF);
    poke(8'h10, 16'h0120); poke(8'h11, 16'h0221); poke(8'h12, 16'h0322); poke(8'h13, 16'h0400);
    run_prog(70);
    chk("R4", "negative overflow flag", {15'h0, ov_flag}, 16'h0001);
    chk("R9", "abend after negative overflow", {15'h0, abend}, 16'h0001);

    // Carry out without signed overflow.
    setup(1'b0, 1'b0, 1'b0);
    poke(8'h20, 16'hFFFE); poke(8'h21, 16'h0003);
    poke(8'h10, 16'h0120); poke(8'h11, 16'h0221); poke(8'h12, 16'h0322); poke(8'h13, 16'h0400);
    run_prog(70);
    chk("R4", "carry leaves flag clear", {15'h0, ov_flag}, 16'h0000);
    chk("R5", "stored carry sum", bmem[8'h22], 16'h0001);

    // System call with the interrupt unit following the flag.
    setup(1'b0, 1'b0, 1'b1);
    poke(8'h20, 16'h1234);
    poke(8'h10, 16'h0605);
    poke(8'h40, 16'h0120); poke(8'h41, 16'h0322); poke(8'h42, 16'h0400);
    run_prog(70);
    chk("R10", "ip after redirect and end", {8'h00, ip}, 16'h0043);
    chk("R10", "svc flag cleared", {15'h0, svc_flag}, 16'h0000);
    chk("R8", "svc index", {8'h00, svc_index}, 16'h0005);
    mem_match("R5", 8'h22);

    // System call with no redirect.
    setup(1'b0, 1'b0, 1'b0);
    poke(8'h20, 16'hBEEF);
    poke(8'h10, 16'h0607); poke(8'h11, 16'h0120); poke(8'h12, 16'h0400);
    run_prog(60);
    chk("R10", "flag kept without jump", {15'h0, svc_flag}, 16'h0001);
    chk("R8", "index latched", {8'h00, svc_index}, 16'h0007);
    chk("R10", "sequential ip", {8'h00, ip}, 16'h0013);

    // Held privilege fault stops after the first instruction.
    setup(1'b0, 1'b1, 1'b0);
    poke(8'h20, 16'h0055);
    poke(8'h10, 16'h0120); poke(8'h11, 16'h0400);
    run_prog(40);
    chk("R9", "fault stop", {14'h0, halted, abend}, 16'h0003);
    chk("R9", "ip unchanged at stop", {8'h00, ip}, 16'h0011);

    // Memory fault with the interrupt unit active: fault wins.
    setup(1'b1, 1'b0, 1'b1);
    poke(8'h10, 16'h0609);
    run_prog(30);
    chk("R9", "fault beats redirect", {8'h00, ip}, 16'h0011);

    // No-operation codes.
    setup(1'b0, 1'b0, 1'b0);
    poke(8'h20, 16'h4321);
    poke(8'h10, 16'h0120); poke(8'h11, 16'h0000); poke(8'h12, 16'h0500);
    poke(8'h13, 16'h0799); poke(8'h14, 16'hFF20); poke(8'h15, 16'h0400);
    run_prog(80);
    chk("R11", "acc untouched by no-ops", acc, 16'h4321);
    chk("R11", "memory untouched", bmem[8'h20], 16'h4321);
    chk("R11", "ip past all no-ops", {8'h00, ip}, 16'h0016);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule